// File: doc/BRIEF.md
# Clock Loop Reference Selector

This block decides which of four monitored clock inputs feeds a digital clock loop, and it steps that loop through its operating modes. A monitor outside the block supplies one valid flag per input. Software-set values supply a priority per input, a manual choice, a revertive enable, a lock-qualification count and a wait-to-restore delay. The loop reports whether it is in lock.

The block drives four outputs: the index of the chosen input, the loop mode, a bandwidth select, and a phase build-out strobe. The bandwidth select picks the wide acquisition bandwidth while the loop is pulling in. The phase build-out strobe lets the loop absorb the phase step of every new reference, so that a change of reference is hitless. If the chosen input fails, the loop goes straight to holdover, provided it has been locked at least once since reset. It leaves holdover as soon as a usable input appears.

Top module: `ref_selector`

## Requirements
- R1: After reset the mode is free-run (mode encoding: 0 free-run, 1 acquiring, 2 locked, 3 holdover), `selIdx` is 0, and both `pboPulse` and `wideBw` are low.
- R2: In automatic mode (`manualEn`=0) an input is a candidate when its valid flag is set and its 4-bit priority field (input i at bits 4i+3..4i of `prioVec`) is nonzero. The candidate with the smallest field value wins, and equal values go to the lowest index. From free-run or holdover, the edge that sees a candidate loads it into `selIdx` and moves to acquiring. With no candidate, the mode does not change.
- R3: In manual mode the input named by `manualSel` is used if it is valid, whatever its priority. If `manualSel` names a different valid input while a reference is in use, the block switches to it on the next edge.
- R4: Acquiring moves to locked on the edge that completes `lockThresh` consecutive acquiring cycles with `lockIn` high (a threshold of 0 counts as 1). A low `lockIn` restarts the count.
- R5: Locked with `lockIn` low returns to acquiring on the next edge, keeping the same input and raising no build-out strobe.
- R6: A failure of the input in use sends the block to holdover on the next edge if it has been locked since reset, and to free-run if it has not. A failure is any of these: the input's valid flag drops; in automatic mode its priority becomes 0; in manual mode it is not the named input and the named input is invalid.
- R7: While no candidate exists, holdover persists. The first edge that sees a candidate selects it and enters acquiring.
- R8: With `revertive`=1 in automatic mode, a valid input with a strictly smaller nonzero priority than the one in use takes over on the (`wtrDelay`+1)-th consecutive edge on which it remains better. If it stops being better, the wait starts again.
- R9: With `revertive`=0 the input in use is kept for as long as it remains valid, even when a better input is available.
- R10: `pboPulse` is high for exactly the one cycle in which a newly loaded `selIdx` first appears. This holds for every selection, including the first one out of free-run or holdover.
- R11: `wideBw` is high exactly while the mode is acquiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-input valid flag from the monitor |
| prioVec | input | 16 | Four 4-bit priorities; 1 is the most preferred, 0 excludes the input |
| manualEn | input | 1 | 1 selects manual mode |
| manualSel | input | 2 | Input index used in manual mode |
| revertive | input | 1 | 1 enables revertive automatic selection |
| lockIn | input | 1 | Lock indication from the loop |
| lockThresh | input | 8 | Consecutive lock cycles needed to declare lock |
| wtrDelay | input | 8 | Wait-to-restore delay in cycles |
| selIdx | output | 2 | Index of the input in use |
| mode | output | 2 | Loop mode (0 free-run, 1 acquiring, 2 locked, 3 holdover) |
| wideBw | output | 1 | 1 selects the acquisition bandwidth |
| pboPulse | output | 1 | Phase build-out request, one cycle per reference change |

## Verification
The hardest situation to reach from the ports is a revertive takeover that was interrupted part-way. To get there, the better input must be valid for fewer edges than the wait-to-restore delay, then drop out, then come back. That only checks R8 if the loop is already locked on a lower-priority input at the time. The bench first locks onto that lower-priority input with a one-cycle lock threshold. It then toggles the better input's valid flag on exact cycle counts and checks that the switch lands on the edge where a fresh full wait completes. A sweep over every valid mask and every priority vector drawn from {0,1,2}, each started from reset, checks the selection rule against a minimum search done in the bench.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_ACQ    = 2'd1,
    MODE_LOCKED = 2'd2,
    MODE_HOLD   = 2'd3
  } loopMode_t;

  // strobes from the mode machine to the datapath
  typedef struct packed {
    logic loadSel;   // load candidate index, fire build-out
    logic runLock;   // lock qualification counter may run
    logic trackWtr;  // wait-to-restore counter may run
  } ctrlStrobe_t;

endpackage

// File: rtl/ref_prio_pick.sv
module ref_prio_pick #(
  parameter int NUM_IN = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*PRIO_W-1:0] prioVec,
  output logic                     bestValid,
  output logic [IDX_W-1:0]         bestIdx,
  output logic [PRIO_W-1:0]        bestPrio
);

  logic [PRIO_W-1:0] prioArr [NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : gUnpack
    assign prioArr[g] = prioVec[g*PRIO_W +: PRIO_W];
  end

  // strict less-than keeps the lowest index on a tie
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestPrio  = '1;
    for (int i = 0; i < NUM_IN; i++) begin
      if (inValid[i] && (prioArr[i] != '0) &&
          (!bestValid || (prioArr[i] < bestPrio))) begin
        bestValid = 1'b1;
        bestIdx   = IDX_W'(i);
        bestPrio  = prioArr[i];
      end
    end
  end

endmodule

// File: rtl/ref_sel_datapath.sv
module ref_sel_datapath
  import ref_sel_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 2,
  parameter int LOCK_W = 8,
  parameter int WTR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*PRIO_W-1:0] prioVec,
  input  logic                     manualEn,
  input  logic [IDX_W-1:0]         manualSel,
  input  logic                     revertive,
  input  logic                     lockIn,
  input  logic [LOCK_W-1:0]        lockThresh,
  input  logic [WTR_W-1:0]         wtrDelay,
  input  ctrlStrobe_t              strobe,
  output logic [IDX_W-1:0]         selIdx,
  output logic                     pboPulse,
  output logic                     candValid,
  output logic                     curOk,
  output logic                     preemptReady,
  output logic                     lockDone
);

  logic              bestValid;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic [PRIO_W-1:0] prioArr [NUM_IN];
  logic [PRIO_W-1:0] curPrio;
  logic [IDX_W-1:0]  candIdx;
  logic              betterAvail;
  logic              wtrDone;
  logic [LOCK_W-1:0] lockCnt;
  logic [LOCK_W:0]   lockNext;
  logic [LOCK_W:0]   lockTarget;
  logic [WTR_W-1:0]  wtrCnt;

  ref_prio_pick #(
    .NUM_IN(NUM_IN),
    .PRIO_W(PRIO_W),
    .IDX_W (IDX_W)
  ) uPick (
    .inValid  (inValid),
    .prioVec  (prioVec),
    .bestValid(bestValid),
    .bestIdx  (bestIdx),
    .bestPrio (bestPrio)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : gPrio
    assign prioArr[g] = prioVec[g*PRIO_W +: PRIO_W];
  end

  assign curPrio = prioArr[selIdx];

  always_comb begin
    candValid   = manualEn ? inValid[manualSel] : bestValid;
    candIdx     = manualEn ? manualSel : bestIdx;
    curOk       = inValid[selIdx] &&
                  (manualEn ? (selIdx == manualSel) : (curPrio != '0));
    betterAvail = !manualEn && revertive && bestValid && (bestPrio < curPrio);
    wtrDone     = (wtrCnt >= wtrDelay);
    if (manualEn) begin
      preemptReady = (manualSel != selIdx) && inValid[manualSel];
    end else begin
      preemptReady = curOk && betterAvail && wtrDone;
    end
  end

  // lock qualification arithmetic, one bit wider than the counter
  assign lockNext   = {1'b0, lockCnt} + {{LOCK_W{1'b0}}, 1'b1};
  assign lockTarget = (lockThresh == '0) ? {{LOCK_W{1'b0}}, 1'b1}
                                         : {1'b0, lockThresh};
  assign lockDone   = lockIn && (lockNext >= lockTarget);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx   <= '0;
      pboPulse <= 1'b0;
      lockCnt  <= '0;
      wtrCnt   <= '0;
    end else begin
      pboPulse <= strobe.loadSel;
      if (strobe.loadSel) begin
        selIdx <= candIdx;
      end

      if (strobe.loadSel || !strobe.runLock || !lockIn) begin
        lockCnt <= '0;
      end else if (!lockDone) begin
        lockCnt <= lockNext[LOCK_W-1:0];
      end

      if (strobe.loadSel || !(strobe.trackWtr && curOk && betterAvail)) begin
        wtrCnt <= '0;
      end else if (!wtrDone) begin
        wtrCnt <= wtrCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ref_sel_control.sv
module ref_sel_control
  import ref_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        candValid,
  input  logic        curOk,
  input  logic        preemptReady,
  input  logic        lockDone,
  input  logic        lockIn,
  output loopMode_t   mode,
  output ctrlStrobe_t strobe
);

  loopMode_t nextMode;
  logic      everLocked;
  logic      nextEver;
  logic      doLoad;

  always_comb begin
    nextMode = mode;
    nextEver = everLocked;
    doLoad   = 1'b0;
    unique case (mode)
      MODE_FREE, MODE_HOLD: begin
        if (candValid) begin
          doLoad   = 1'b1;
          nextMode = MODE_ACQ;
        end
      end
      MODE_ACQ, MODE_LOCKED: begin
        if (preemptReady) begin
          doLoad   = 1'b1;
          nextMode = MODE_ACQ;
        end else if (!curOk) begin
          nextMode = everLocked ? MODE_HOLD : MODE_FREE;
        end else if ((mode == MODE_ACQ) && lockDone) begin
          nextMode = MODE_LOCKED;
          nextEver = 1'b1;
        end else if ((mode == MODE_LOCKED) && !lockIn) begin
          nextMode = MODE_ACQ;
        end
      end
      default: nextMode = MODE_FREE;
    endcase
  end

  always_comb begin
    strobe.loadSel  = doLoad;
    strobe.runLock  = (mode == MODE_ACQ);
    strobe.trackWtr = (mode == MODE_ACQ) || (mode == MODE_LOCKED);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= MODE_FREE;
      everLocked <= 1'b0;
    end else begin
      mode       <= nextMode;
      everLocked <= nextEver;
    end
  end

endmodule

// File: rtl/ref_selector.sv
module ref_selector
  import ref_sel_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 2,
  parameter int LOCK_W = 8,
  parameter int WTR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*PRIO_W-1:0] prioVec,
  input  logic                     manualEn,
  input  logic [IDX_W-1:0]         manualSel,
  input  logic                     revertive,
  input  logic                     lockIn,
  input  logic [LOCK_W-1:0]        lockThresh,
  input  logic [WTR_W-1:0]         wtrDelay,
  output logic [IDX_W-1:0]         selIdx,
  output logic [1:0]               mode,
  output logic                     wideBw,
  output logic                     pboPulse
);

  ctrlStrobe_t strobe;
  loopMode_t   modeQ;
  logic        candValid;
  logic        curOk;
  logic        preemptReady;
  logic        lockDone;

  ref_sel_datapath #(
    .NUM_IN(NUM_IN),
    .PRIO_W(PRIO_W),
    .IDX_W (IDX_W),
    .LOCK_W(LOCK_W),
    .WTR_W (WTR_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .prioVec     (prioVec),
    .manualEn    (manualEn),
    .manualSel   (manualSel),
    .revertive   (revertive),
    .lockIn      (lockIn),
    .lockThresh  (lockThresh),
    .wtrDelay    (wtrDelay),
    .strobe      (strobe),
    .selIdx      (selIdx),
    .pboPulse    (pboPulse),
    .candValid   (candValid),
    .curOk       (curOk),
    .preemptReady(preemptReady),
    .lockDone    (lockDone)
  );

  ref_sel_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .candValid   (candValid),
    .curOk       (curOk),
    .preemptReady(preemptReady),
    .lockDone    (lockDone),
    .lockIn      (lockIn),
    .mode        (modeQ),
    .strobe      (strobe)
  );

  assign mode   = modeQ;
  assign wideBw = (modeQ == MODE_ACQ);

endmodule

// File: rtl/ref_selector_chk.sv
module ref_selector_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] selIdx,
  input logic [1:0]       mode,
  input logic             pboPulse,
  input logic             lockIn
);

  // R10: any change of the index in use comes with a build-out request
  p_pbo_on_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    (selIdx != $past(selIdx)) |-> pboPulse);

  // R2: a fresh selection always lands in the acquiring mode
  p_pbo_in_acq_r2: assert property (@(posedge clk) disable iff (!rstN)
    pboPulse |-> (mode == 2'd1));

  // R4: locked is only held or entered after lock was seen on the prior edge
  p_lock_seen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> $past(lockIn));

  // R6: once locked, the loop never falls back to free-run
  p_no_free_after_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |=> (mode != 2'd0));

endmodule

bind ref_selector ref_selector_chk #(.IDX_W(IDX_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .selIdx  (selIdx),
  .mode    (mode),
  .pboPulse(pboPulse),
  .lockIn  (lockIn)
);

// File: tb/tb_ref_selector.sv
module tb_ref_selector;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  inValid;
  logic [15:0] prioVec;
  logic        manualEn;
  logic [1:0]  manualSel;
  logic        revertive;
  logic        lockIn;
  logic [7:0]  lockThresh;
  logic [7:0]  wtrDelay;
  logic [1:0]  selIdx;
  logic [1:0]  mode;
  logic        wideBw;
  logic        pboPulse;

  int totalCnt = 0;
  int passCnt  = 0;

  always #5 clk = ~clk;

  ref_selector dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .prioVec(prioVec),
    .manualEn(manualEn), .manualSel(manualSel), .revertive(revertive),
    .lockIn(lockIn), .lockThresh(lockThresh), .wtrDelay(wtrDelay),
    .selIdx(selIdx), .mode(mode), .wideBw(wideBw), .pboPulse(pboPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = '0; prioVec = '0; manualEn = 1'b0; manualSel = '0;
    revertive = 1'b0; lockIn = 1'b0; lockThresh = 8'd1; wtrDelay = '0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic expMode(input string req, input int m);
    check(mode == m[1:0], req, mode, m);
  endtask

  function automatic int bestOf(input logic [3:0] vm, input logic [15:0] pv);
    int best = -1;
    int bp = 99;
    for (int i = 0; i < 4; i++) begin
      int p = int'(pv[i*4 +: 4]);
      if (vm[i] && p != 0 && p < bp) begin
        bp = p; best = i;
      end
    end
    return best;
  endfunction

  initial begin
    #2000000;
    totalCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    check(mode == 2'd0 && selIdx == 2'd0 && !pboPulse && !wideBw, "R1",
          {mode, selIdx, pboPulse, wideBw}, 0);

    // R2 sweep: all valid masks, priorities from {0,1,2}
    for (int vm = 0; vm < 16; vm++) begin
      for (int pc = 0; pc < 81; pc++) begin
        logic [15:0] pv;
        int exp;
        int t;
        t = pc;
        pv = '0;
        for (int i = 0; i < 4; i++) begin
          pv[i*4 +: 4] = 4'(t % 3);
          t = t / 3;
        end
        doReset();
        inValid = 4'(vm); prioVec = pv;
        tick();
        exp = bestOf(4'(vm), pv);
        if (exp < 0) check(mode == 2'd0 && !pboPulse, "R2 none", mode, 0);
        else check(mode == 2'd1 && pboPulse && int'(selIdx) == exp, "R2 pick",
                   int'(selIdx), exp);
      end
    end

    // R4 R5 R6 R7 R10 R11 lock sequence
    doReset();
    prioVec = 16'h1111; inValid = 4'b0001; lockThresh = 8'd3;
    tick();
    check(pboPulse && selIdx == 0, "R10 pulse on select", pboPulse, 1);
    check(wideBw, "R11 wide in acq", wideBw, 1);
    tick();
    check(!pboPulse, "R10 single cycle", pboPulse, 0);
    lockIn = 1'b1; tick(); tick();
    expMode("R4 two of three", 1);
    lockIn = 1'b0; tick();
    lockIn = 1'b1; tick(); tick();
    expMode("R4 count restarted", 1);
    tick();
    expMode("R4 locked", 2);
    check(!wideBw, "R11 narrow when locked", wideBw, 0);
    lockIn = 1'b0; tick();
    expMode("R5 back to acq", 1);
    check(!pboPulse && selIdx == 0, "R5 no pulse same input", pboPulse, 0);
    lockIn = 1'b1; tick(); tick(); tick();
    expMode("R4 relocked", 2);
    inValid = 4'b0000; tick();
    expMode("R6 holdover", 3);
    tick(); tick(); tick();
    expMode("R7 stays holdover", 3);
    check(!wideBw, "R11 narrow in holdover", wideBw, 0);
    inValid = 4'b0100; tick();
    expMode("R7 reselect", 1);
    check(selIdx == 2 && pboPulse, "R7 new input with pulse", selIdx, 2);

    // R6 failure before any lock goes to free-run
    doReset();
    prioVec = 16'h1111; inValid = 4'b0010; tick();
    inValid = 4'b0000; tick();
    expMode("R6 free-run unlocked", 0);

    // R6 priority cleared in auto mode
    doReset();
    prioVec = 16'h0021; inValid = 4'b0011; tick();
    check(selIdx == 0, "R2 lower value wins", selIdx, 0);
    prioVec = 16'h0020; tick();
    expMode("R6 excluded by zero priority", 0);

    // R8 revertive with an interrupted wait
    doReset();
    prioVec = 16'h0021; inValid = 4'b0010; revertive = 1'b1;
    wtrDelay = 8'd3; lockThresh = 8'd1; lockIn = 1'b1;
    tick(); tick();
    expMode("R8 locked on lower priority", 2);
    inValid = 4'b0011; tick(); tick();
    inValid = 4'b0010; tick();
    inValid = 4'b0011;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(selIdx == 1, "R8 waiting", selIdx, 1);
    end
    tick();
    check(selIdx == 0 && pboPulse && mode == 2'd1, "R8 restored", selIdx, 0);

    // R9 nonrevertive keeps current input
    doReset();
    prioVec = 16'h0021; inValid = 4'b0010; wtrDelay = '0; lockIn = 1'b1;
    tick(); tick();
    inValid = 4'b0011;
    for (int k = 0; k < 10; k++) tick();
    check(selIdx == 1 && mode == 2'd2, "R9 kept", selIdx, 1);

    // R3 manual selection ignores priority
    doReset();
    manualEn = 1'b1; manualSel = 2'd2; inValid = 4'b1111; tick();
    check(selIdx == 2 && pboPulse, "R3 manual pick", selIdx, 2);
    manualSel = 2'd3; tick();
    check(selIdx == 3 && pboPulse && mode == 2'd1, "R3 manual switch", selIdx, 3);
    manualSel = 2'd1; inValid = 4'b1101; tick();
    expMode("R6 manual target invalid", 0);

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule